// File: doc/BRIEF.md
# Dual Interval Timer

The block holds two countdown timers that run side by side. Each timer has an 8-bit reload value and its own resolution: the first timer advances once every 80 time-base ticks and the second once every 360, where a tick is a one-cycle pulse on `us_tick`, normally one microsecond apart. A timer whose reload value is `r` runs for `255 - r` counts, so larger reload values give shorter periods. The value 255 would give a period of zero counts and is treated as one count.

When an enabled timer runs out, it raises its own expiry flag. It then starts the same period again without help. The interrupt request is high while either flag is set. Host software writes the registers through one shared 8-bit data bus with four write strobes: one reload strobe for each timer, a control strobe, and an enable strobe. A control write clears both flags and can restart either timer. An enable write turns each timer on or off, and a timer that is off keeps its count where it stopped.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both flags and `irq_o` are 0, both timers are disabled and both stored reload values are 0.
- R2: An enabled timer decrements only on cycles where `us_tick` is 1. Timer A's flag (`flag_o[0]`) sets (255 - r) x RES_A ticks after its countdown was loaded, with RES_A = 80 by default; cycles without a tick do not count.
- R3: Timer B's flag (`flag_o[1]`) sets (255 - r) x RES_B ticks after its countdown was loaded, with RES_B = 360 by default.
- R4: A reload strobe (`rld_a_wr` or `rld_b_wr`) stores `wr_data` and, in the same edge, loads the countdown with the new period. Any count already in progress is discarded.
- R5: A control write with `wr_data[2]` = 1 reloads timer A's countdown from its stored reload value. A control write with `wr_data[3]` = 1 does the same for timer B.
- R6: Any control write clears both flags, and `irq_o` falls with them. An expiry on the same edge as the control write still sets its flag.
- R7: An enable write sets timer A active from `wr_data[0]` and timer B active from `wr_data[1]`. An inactive timer keeps its countdown unchanged and never expires.
- R8: On expiry a timer sets its flag, which drives `irq_o` to 1. The timer reloads its period, so an enabled timer expires again every period.
- R9: A reload value of 255 gives a period of one count (RES ticks). The countdown never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | Time-base tick, one cycle wide |
| wr_data | input | 8 | Shared register write data |
| rld_a_wr | input | 1 | Write strobe for timer A's reload value |
| rld_b_wr | input | 1 | Write strobe for timer B's reload value |
| ctrl_wr | input | 1 | Control write: restart bits 2 (A) and 3 (B), clears flags |
| en_wr | input | 1 | Enable write: bit 0 enables A, bit 1 enables B |
| flag_o | output | 2 | Expiry flags, bit 0 for timer A and bit 1 for timer B |
| irq_o | output | 1 | Interrupt request, high while any flag is set |

## Verification
The hardest case to reach from the ports is a control write that lands on the same edge as an expiry. The bench restarts timer A through a control write and counts edges from that write. It then issues a second control write on exactly the edge where the count runs out, and expects the flag to rise instead of being cleared. The hold behaviour is exercised the same way: the bench disables the timer, or removes the tick, partway through a count and checks that the expiry moves later by exactly the length of the pause.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned RLD_W = 8;
  localparam int unsigned NUM_CH = 2;

  // Counts in one period for a reload value; 255 is promoted to a single count.
  function automatic int unsigned counts_of(input logic [RLD_W-1:0] r);
    int unsigned c;
    c = 255 - int'(r);
    if (c == 0) c = 1;
    return c;
  endfunction

  // Ticks in one period for a given resolution.
  function automatic int unsigned span_of(input logic [RLD_W-1:0] r, input int unsigned res);
    return counts_of(r) * res;
  endfunction
endpackage

// File: rtl/dit_chan.sv
module dit_chan #(
  parameter int unsigned RES   = 80,
  parameter int unsigned CNT_W = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       active,
  input  logic                       load,
  input  logic                       restart,
  input  logic [dit_pkg::RLD_W-1:0]  reload_in,
  output logic                       expire,
  output logic [CNT_W-1:0]           remain
);
  logic [dit_pkg::RLD_W-1:0] reload_q;
  logic [CNT_W-1:0]          rem_q;
  logic                      step;

  assign step   = active && tick && !load && !restart;
  assign expire = step && (rem_q == CNT_W'(1));
  assign remain = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      rem_q    <= CNT_W'(dit_pkg::span_of('0, RES));
    end else if (load) begin
      reload_q <= reload_in;
      rem_q    <= CNT_W'(dit_pkg::span_of(reload_in, RES));
    end else if (restart) begin
      rem_q <= CNT_W'(dit_pkg::span_of(reload_q, RES));
    end else if (step) begin
      if (rem_q == CNT_W'(1)) rem_q <= CNT_W'(dit_pkg::span_of(reload_q, RES));
      else                    rem_q <= rem_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dit_flags.sv
module dit_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= '0;
    else if (clear) flag_q <= set;
    else            flag_q <= flag_q | set;
  end

  assign flags = flag_q;
  assign irq   = |flag_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int unsigned RES_A = 80,
  parameter int unsigned RES_B = 360
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      us_tick,
  input  logic [dit_pkg::RLD_W-1:0] wr_data,
  input  logic                      rld_a_wr,
  input  logic                      rld_b_wr,
  input  logic                      ctrl_wr,
  input  logic                      en_wr,
  output logic [1:0]                flag_o,
  output logic                      irq_o
);
  localparam int unsigned RES_MAX = (RES_A > RES_B) ? RES_A : RES_B;
  localparam int unsigned CNT_W   = $clog2(255 * RES_MAX + 1);

  logic [1:0]       active_q;
  logic [1:0]       load_w;
  logic [1:0]       restart_w;
  logic [1:0]       expire_w;
  logic [CNT_W-1:0] rem_w [2];

  assign load_w    = {rld_b_wr, rld_a_wr};
  assign restart_w = {ctrl_wr & wr_data[3], ctrl_wr & wr_data[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_q <= '0;
    else if (en_wr) active_q <= wr_data[1:0];
  end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    localparam int unsigned RES = (g == 0) ? RES_A : RES_B;
    dit_chan #(.RES(RES), .CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (us_tick),
      .active    (active_q[g]),
      .load      (load_w[g]),
      .restart   (restart_w[g]),
      .reload_in (wr_data),
      .expire    (expire_w[g]),
      .remain    (rem_w[g])
    );
  end

  dit_flags #(.N(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ctrl_wr),
    .set   (expire_w),
    .flags (flag_o),
    .irq   (irq_o)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int unsigned CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       wr_data,
  input logic             rld_a_wr,
  input logic             ctrl_wr,
  input logic [1:0]       active,
  input logic [1:0]       expire,
  input logic [1:0]       flags,
  input logic             irq,
  input logic [CNT_W-1:0] rem_a,
  input logic [CNT_W-1:0] rem_b
);
  // R6
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && expire == 2'b00) |=> (flags == 2'b00 && !irq));

  // R8
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> irq);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|expire));

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && expire == 2'b00) |=> $stable(flags));

  // R7
  hold_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active[0] && !rld_a_wr && !(ctrl_wr && wr_data[2])) |=> $stable(rem_a));

  // R9
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_a != '0 && rem_b != '0));
endmodule

bind dual_interval_timer dit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_data  (wr_data),
  .rld_a_wr (rld_a_wr),
  .ctrl_wr  (ctrl_wr),
  .active   (active_q),
  .expire   (expire_w),
  .flags    (flag_o),
  .irq      (irq_o),
  .rem_a    (rem_w[0]),
  .rem_b    (rem_w[1])
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  localparam int RA = 80;
  localparam int RB = 360;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       us_tick = 1;
  logic [7:0] wr_data = 0;
  logic       rld_a_wr = 0, rld_b_wr = 0, ctrl_wr = 0, en_wr = 0;
  logic [1:0] flag_o;
  logic       irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int expq [2][$];
  logic [1:0] prev_flags = 0;
  string tagq [2][$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_data(wr_data),
    .rld_a_wr(rld_a_wr), .rld_b_wr(rld_b_wr), .ctrl_wr(ctrl_wr), .en_wr(en_wr),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  function automatic int period(input int r, input int res);
    int c = 255 - r;
    return (c == 0 ? 1 : c) * res;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: called at a negedge, returns at the negedge after the sampling edge.
  task automatic wr(input int which, input logic [7:0] d, output int at);
    wr_data = d;
    case (which)
      0: rld_a_wr = 1;
      1: rld_b_wr = 1;
      2: ctrl_wr = 1;
      default: en_wr = 1;
    endcase
    @(posedge clk);
    @(negedge clk);
    at = cyc;
    rld_a_wr = 0; rld_b_wr = 0; ctrl_wr = 0; en_wr = 0;
  endtask

  task automatic expect_rise(input int ch, input int at, input string req);
    expq[ch].push_back(at);
    tagq[ch].push_back(req);
  endtask

  task automatic drain();
    while (expq[0].size() != 0 || expq[1].size() != 0) @(negedge clk);
  endtask

  task automatic park();
    int t;
    wr(3, 8'h00, t);
    wr(2, 8'h00, t);
  endtask

  // Monitor: compares each flag rise with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (flag_o[i] && !prev_flags[i]) begin
          if (expq[i].size() == 0) begin
            chk(0, "R8 unexpected expiry", cyc, -1);
          end else begin
            int e;
            string r;
            e = expq[i].pop_front();
            r = tagq[i].pop_front();
            chk(cyc == e, r, cyc, e);
            chk(irq_o == 1'b1, "R8 irq with flag", irq_o, 1);
          end
        end
      end
      prev_flags <= flag_o;
    end
  end

  initial begin
    int t, l, c, d, e;
    #1;
    chk(flag_o == 0 && irq_o == 0, "R1 reset outputs", {flag_o, irq_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(flag_o == 0 && irq_o == 0, "R1 after release", {flag_o, irq_o}, 0);

    // R2 / R8: timer A, reload 250, then periodic re-expiry
    wr(3, 8'h01, t);
    wr(0, 8'd250, l);
    expect_rise(0, l + period(250, RA), "R2 timer A period");
    drain();
    wr(2, 8'h00, c);
    chk(flag_o == 0 && irq_o == 0, "R6 control write clears", {flag_o, irq_o}, 0);
    expect_rise(0, l + 2 * period(250, RA), "R8 auto reload period");
    drain();
    park();

    // R3: timer B, reload 253
    wr(3, 8'h02, t);
    wr(1, 8'd253, l);
    expect_rise(1, l + period(253, RB), "R3 timer B period");
    drain();
    park();

    // R9: reload 255 is one count
    wr(3, 8'h01, t);
    wr(0, 8'd255, l);
    expect_rise(0, l + period(255, RA), "R9 reload 255 one count");
    drain();
    park();

    // R4: rewrite reload mid-count
    wr(3, 8'h01, t);
    wr(0, 8'd250, l);
    repeat (100) @(negedge clk);
    wr(0, 8'd254, l);
    expect_rise(0, l + period(254, RA), "R4 reload write restarts");
    drain();
    park();

    // R5: restart both from stored values (A=254, B=253)
    wr(3, 8'h03, t);
    wr(2, 8'h0C, c);
    expect_rise(0, c + period(254, RA), "R5 restart A");
    expect_rise(1, c + period(253, RB), "R5 restart B");
    drain();
    park();

    // R7: disable mid-count holds the countdown
    wr(3, 8'h01, t);
    wr(2, 8'h04, c);
    repeat (30) @(negedge clk);
    wr(3, 8'h00, d);
    repeat (50) @(negedge clk);
    chk(flag_o == 0, "R7 no expiry while inactive", flag_o, 0);
    wr(3, 8'h01, e);
    expect_rise(0, e + period(254, RA) - (d - c), "R7 hold while disabled");
    drain();
    park();

    // R2: missing ticks do not count
    wr(3, 8'h01, t);
    wr(2, 8'h04, c);
    repeat (20) @(negedge clk);
    us_tick = 0;
    repeat (40) @(negedge clk);
    us_tick = 1;
    expect_rise(0, c + period(254, RA) + 40, "R2 counts only ticks");
    drain();
    park();

    // R6: control write on the expiry edge does not lose the expiry
    wr(3, 8'h01, t);
    wr(2, 8'h04, c);
    expect_rise(0, c + period(254, RA), "R6 expiry beats same-edge clear");
    while (cyc < c + period(254, RA) - 1) @(negedge clk);
    wr(2, 8'h00, t);
    chk(flag_o[0] == 1'b1, "R6 flag after same-edge clear", flag_o[0], 1);
    drain();
    park();
    chk(flag_o == 0 && irq_o == 0, "R6 final clear", {flag_o, irq_o}, 0);

    repeat (5) @(negedge clk);
    chk(expq[0].size() == 0 && expq[1].size() == 0, "R8 all expiries seen",
        expq[0].size() + expq[1].size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule